// File: doc/BRIEF.md
# ECC Check-Bit Fault Injector

This block sits on the write path into a transmit buffer and deliberately damages the ECC check bits of selected quadwords. Diagnostics can then prove that the ECC checkers further down the path detect and classify errors correctly. Each beat carries four quadwords, and each quadword has its own check-bit field. A per-quadword force mask chooses the quadwords to damage. A severity select chooses between a single-bit and a double-bit corruption. Only beats that target memory space are affected.

Injection is level-sensitive. While a mask bit stays set, every qualifying beat that passes through has its check bits damaged in that quadword. Nothing is armed or consumed, so clearing the mask bit stops the corruption on the next beat. The data bits themselves are never changed. Every beat leaves the block exactly one clock after it enters, whether or not it was altered.

Top module: `ecc_err_inject`

## Requirements
- R1: While reset is asserted, and after it until the first valid beat, `out_valid` is 0 and `out_data` and `out_ecc` are all zeros.
- R2: A beat presented with `in_valid`=1 appears on `out_valid`/`out_data` one clock later. Its data bits are unchanged in every case.
- R3: For a quadword whose force bit is 0, the outgoing check field equals the incoming one.
- R4: For a memory-space beat (`in_mem_space`=1) with the force bit of quadword i set and `in_dbl_sel`=0, only bit 0 of that quadword's check field is inverted.
- R5: For a memory-space beat with the force bit of quadword i set and `in_dbl_sel`=1, bits 0 and 1 of that quadword's check field are inverted and no other bits change.
- R6: A beat with `in_mem_space`=0 passes all check fields unchanged, whatever the force mask and severity select are.
- R7: Injection is level-based. Every qualifying beat is corrupted while the force bit stays set, and beats after the bit is cleared pass clean.
- R8: Quadword i occupies `in_data[i*64 +: 64]` and `in_ecc[i*8 +: 8]`. Force bit i affects only that quadword's check field.
- R9: A clock with `in_valid`=0 drives `out_valid` to 0 on the next clock and leaves `out_data` and `out_ecc` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat present on the input |
| in_mem_space | input | 1 | Beat targets a memory-space address |
| in_force_mask | input | 4 | One force bit for each quadword |
| in_dbl_sel | input | 1 | 1 selects double-bit corruption, 0 selects single-bit |
| in_data | input | 256 | Four quadwords of data |
| in_ecc | input | 32 | Four 8-bit check fields |
| out_valid | output | 1 | Registered beat present |
| out_data | output | 256 | Registered data, never altered |
| out_ecc | output | 32 | Registered check fields after injection |

## Verification
The bench sends memory-space beats with one-hot, mixed and full masks, at both severities. A design with swapped lane slicing would damage the wrong quadword. A design with the wrong flip pattern would yield an error that is uncorrectable when it should be correctable, or the reverse. I/O-space beats carry a full mask, so a design that ignores the space qualifier shows corrupted checks where there should be none. Back-to-back beats under a held mask, followed by a cleared mask, expose a one-shot or a sticky implementation. Idle cycles placed between beats catch output registers that load on every clock instead of only on valid beats.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;

    // Kind of corruption requested for one quadword
    typedef enum logic [1:0] {
        INJ_NONE   = 2'd0,
        INJ_SINGLE = 2'd1,
        INJ_DOUBLE = 2'd2
    } inj_kind_e;

endpackage

// File: rtl/ecc_inj_ctrl.sv
// Decodes the per-lane injection kind from the qualifiers of a beat.
module ecc_inj_ctrl
    import ecc_inj_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                   beat_valid,
    input  logic                   mem_space,
    input  logic [LANES-1:0]       force_mask,
    input  logic                   dbl_sel,
    output inj_kind_e [LANES-1:0]  kind
);

    logic qualify;

    always_comb begin
        qualify = beat_valid && mem_space;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane_dec
        always_comb begin
            if (!qualify || !force_mask[g]) begin
                kind[g] = INJ_NONE;
            end else if (dbl_sel) begin
                kind[g] = INJ_DOUBLE;
            end else begin
                kind[g] = INJ_SINGLE;
            end
        end
    end

endmodule

// File: rtl/ecc_inj_lane.sv
// One quadword lane: registers the data and the (possibly damaged) check field.
module ecc_inj_lane
    import ecc_inj_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ECC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  inj_kind_e         kind,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ECC_W-1:0]  ecc_i,
    output logic [DATA_W-1:0] data_o,
    output logic [ECC_W-1:0]  ecc_o
);

    localparam logic [ECC_W-1:0] SBE_PAT = {{(ECC_W-1){1'b0}}, 1'b1};
    localparam logic [ECC_W-1:0] DBE_PAT = {{(ECC_W-2){1'b0}}, 2'b11};

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [ECC_W-1:0]  ecc;
    } lane_st_t;

    lane_st_t         st_d, st_q;
    logic [ECC_W-1:0] flip_d;

    always_comb begin
        st_d = st_q;
        unique case (kind)
            INJ_SINGLE: flip_d = SBE_PAT;
            INJ_DOUBLE: flip_d = DBE_PAT;
            default:    flip_d = '0;
        endcase
        if (load) begin
            st_d.data = data_i;
            st_d.ecc  = ecc_i ^ flip_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;
    assign ecc_o  = st_q.ecc;

    // R3: an unforced lane keeps its check field intact
    assert_clean_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && kind == INJ_NONE) |=> (ecc_o == $past(ecc_i)));

    // R4: single-bit kind changes exactly bit 0
    assert_single_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && kind == INJ_SINGLE) |=>
            ($countones(ecc_o ^ $past(ecc_i)) == 1 && ecc_o[0] != $past(ecc_i[0])));

    // R5: double-bit kind changes exactly bits 0 and 1
    assert_double_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && kind == INJ_DOUBLE) |=>
            ($countones(ecc_o ^ $past(ecc_i)) == 2 && ecc_o[1:0] == ~$past(ecc_i[1:0])));

endmodule

// File: rtl/ecc_err_inject.sv
// Top: four-lane check-bit fault injector, one registered stage.
module ecc_err_inject
    import ecc_inj_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int DATA_W = 64,
    parameter int ECC_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_mem_space,
    input  logic [LANES-1:0]          in_force_mask,
    input  logic                      in_dbl_sel,
    input  logic [LANES*DATA_W-1:0]   in_data,
    input  logic [LANES*ECC_W-1:0]    in_ecc,
    output logic                      out_valid,
    output logic [LANES*DATA_W-1:0]   out_data,
    output logic [LANES*ECC_W-1:0]    out_ecc
);

    localparam int BUS_W = LANES * DATA_W;
    localparam int CHK_W = LANES * ECC_W;

    inj_kind_e [LANES-1:0] kind;
    logic                  valid_d, valid_q;

    ecc_inj_ctrl #(.LANES(LANES)) u_ctrl (
        .beat_valid (in_valid),
        .mem_space  (in_mem_space),
        .force_mask (in_force_mask),
        .dbl_sel    (in_dbl_sel),
        .kind       (kind)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ecc_inj_lane #(.DATA_W(DATA_W), .ECC_W(ECC_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (in_valid),
            .kind   (kind[g]),
            .data_i (in_data[g*DATA_W +: DATA_W]),
            .ecc_i  (in_ecc[g*ECC_W +: ECC_W]),
            .data_o (out_data[g*DATA_W +: DATA_W]),
            .ecc_o  (out_ecc[g*ECC_W +: ECC_W])
        );
    end

    always_comb begin
        valid_d = in_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= valid_d;
        end
    end

    assign out_valid = valid_q;

    // R2: one-cycle latency, data untouched
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_data == $past(in_data)));

    // R6: non-memory-space beats never carry injected errors
    assert_io_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mem_space) |=> (out_ecc == $past(in_ecc)));

    // R9: idle cycles drop valid and hold the output registers
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_ecc)));

    initial begin
        assert_widths_R8: assert (BUS_W == LANES * DATA_W && CHK_W == LANES * ECC_W && ECC_W >= 2);
    end

endmodule

// File: tb/ecc_err_inject_test.sv
module ecc_err_inject_test;

    localparam int LANES  = 4;
    localparam int DATA_W = 64;
    localparam int ECC_W  = 8;
    localparam int BUS_W  = LANES * DATA_W;
    localparam int CHK_W  = LANES * ECC_W;
    localparam int SEG    = DATA_W / ECC_W;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n;
    logic             in_valid;
    logic             in_mem_space;
    logic [LANES-1:0] in_force_mask;
    logic             in_dbl_sel;
    logic [BUS_W-1:0] in_data;
    logic [CHK_W-1:0] in_ecc;
    logic             out_valid;
    logic [BUS_W-1:0] out_data;
    logic [CHK_W-1:0] out_ecc;

    ecc_err_inject #(.LANES(LANES), .DATA_W(DATA_W), .ECC_W(ECC_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mem_space(in_mem_space),
        .in_force_mask(in_force_mask), .in_dbl_sel(in_dbl_sel), .in_data(in_data),
        .in_ecc(in_ecc), .out_valid(out_valid), .out_data(out_data), .out_ecc(out_ecc)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [BUS_W-1:0] last_d;
    logic [CHK_W-1:0] last_e;

    // Byte-parity check code used as stand-in ECC
    function automatic logic [CHK_W-1:0] code_of(input logic [BUS_W-1:0] d);
        logic [CHK_W-1:0] c;
        for (int l = 0; l < LANES; l++)
            for (int b = 0; b < ECC_W; b++)
                c[l*ECC_W + b] = ^d[l*DATA_W + b*SEG +: SEG];
        return c;
    endfunction

    // Expected check fields from the requirements R3..R8
    function automatic logic [CHK_W-1:0] expect_code(input logic [BUS_W-1:0] d, input logic mem,
                                                     input logic [LANES-1:0] mask, input logic dbl);
        logic [CHK_W-1:0] c;
        c = code_of(d);
        if (mem) begin
            for (int l = 0; l < LANES; l++) begin
                if (mask[l]) begin
                    c[l*ECC_W] = ~c[l*ECC_W];
                    if (dbl) c[l*ECC_W + 1] = ~c[l*ECC_W + 1];
                end
            end
        end
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] pattern(input int seed);
        logic [BUS_W-1:0] p;
        for (int l = 0; l < LANES; l++)
            p[l*DATA_W +: DATA_W] = 64'h0F1E_2D3C_4B5A_6978 ^ (64'(seed) * 64'h9E37_79B9_7F4A_7C15)
                                    ^ (64'(l) << (8 * l + 3));
        return p;
    endfunction

    task automatic check(input string req, input string what, input logic [BUS_W-1:0] act,
                         input logic [BUS_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One beat: drive at a falling edge, check at the next falling edge
    task automatic beat(input logic v, input logic mem, input logic [LANES-1:0] mask,
                        input logic dbl, input logic [BUS_W-1:0] d, input string req);
        in_valid = v; in_mem_space = mem; in_force_mask = mask; in_dbl_sel = dbl;
        in_data = d; in_ecc = code_of(d);
        if (v) begin
            last_d = d;
            last_e = expect_code(d, mem, mask, dbl);
        end
        @(negedge clk);
        check(req, "valid", BUS_W'(out_valid), BUS_W'(v));
        check(req, "data", out_data, last_d);
        check(req, "ecc", BUS_W'(out_ecc), BUS_W'(last_e));
    endtask

    task automatic test_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_mem_space = 1'b0; in_force_mask = '0;
        in_dbl_sel = 1'b0; in_data = '1; in_ecc = '1;
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", BUS_W'(out_valid), '0);
        check("R1", "data in reset", out_data, '0);
        check("R1", "ecc in reset", BUS_W'(out_ecc), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "data after reset", out_data, '0);
        last_d = '0; last_e = '0;
    endtask

    task automatic test_clean_pass();   // R2, R3
        beat(1'b1, 1'b1, 4'b0000, 1'b0, pattern(1), "R3");
        beat(1'b1, 1'b1, 4'b0000, 1'b1, pattern(2), "R2");
    endtask

    task automatic test_single();        // R4, R8 one-hot lanes
        for (int l = 0; l < LANES; l++)
            beat(1'b1, 1'b1, LANES'(1) << l, 1'b0, pattern(10 + l), "R4_R8");
    endtask

    task automatic test_double();        // R5, mixed masks
        beat(1'b1, 1'b1, 4'b1010, 1'b1, pattern(20), "R5");
        beat(1'b1, 1'b1, 4'b1111, 1'b1, pattern(21), "R5");
        beat(1'b1, 1'b1, 4'b0110, 1'b0, pattern(22), "R4");
    endtask

    task automatic test_io_space();      // R6
        beat(1'b1, 1'b0, 4'b1111, 1'b0, pattern(30), "R6");
        beat(1'b1, 1'b0, 4'b1111, 1'b1, pattern(31), "R6");
    endtask

    task automatic test_persist();       // R7 level-based, not one-shot, not sticky
        for (int k = 0; k < 3; k++)
            beat(1'b1, 1'b1, 4'b0101, 1'b0, pattern(40 + k), "R7");
        beat(1'b1, 1'b1, 4'b0000, 1'b0, pattern(50), "R7");
        beat(1'b1, 1'b1, 4'b1001, 1'b1, pattern(51), "R7");
    endtask

    task automatic test_idle_hold();     // R9
        beat(1'b1, 1'b1, 4'b0011, 1'b1, pattern(60), "R9");
        beat(1'b0, 1'b1, 4'b1111, 1'b0, pattern(61), "R9");
        beat(1'b0, 1'b0, 4'b0000, 1'b1, '0, "R9");
        beat(1'b1, 1'b0, 4'b0000, 1'b0, pattern(62), "R2");
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        test_clean_pass();
        test_single();
        test_double();
        test_io_space();
        test_persist();
        test_idle_hold();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule